// File: doc/BRIEF.md
# Deferred Instruction-Fetch Fault Tracker

This block sits between the fetch unit and the decode stage of a small pipelined processor. Prefetched 16-bit instruction words enter a short in-order buffer, and each word carries a flag that records whether its bus fetch ended in an error. A faulted fetch raises nothing when it returns. The flag travels with the word. If a change of program flow flushes the buffer, faulted words that were never consumed are dropped without a trace.

Decode states how many words (1 to 3) the current instruction needs and requests consumption. The request takes effect only when all of those words are present. If any of them is flagged, the block raises a one-cycle access-error request that carries the address of the instruction's first word. It also raises an abort level that blocks every architectural write of that instruction until the exception logic redirects the flow with a flush. If none of the words is flagged, the words are handed on as an issued instruction together with their address.

Top module: `ifetch_fault_tracker`

## Requirements
- R1: After reset the buffer is empty, `fetch_ready_o` is 1, and `instr_issue_o`, `acc_err_o` and `abort_o` are 0.
- R2: A fetch response with `fetch_err_i`=1 does not by itself cause `acc_err_o` or `abort_o` in any cycle.
- R3: A consume request (`dec_take_i`=1) with `dec_len_i`=N, where all N head words are present and none is flagged, makes `instr_issue_o` 1 for one cycle after the edge. `instr_words_o` then holds the head words in fetch order, with word i in bits [16*i+15:16*i] and unused slots 0. `instr_pc_o` is the head address. The head address then advances by 2*N.
- R4: A consume request whose N head words are all present and include at least one flagged word makes `acc_err_o` a one-cycle pulse after the edge, with `acc_err_pc_o` equal to the address of the first word and `instr_issue_o` 0.
- R5: A flagged word beyond the N words of the current instruction causes no error. It raises the error later, when it is consumed as part of another instruction.
- R6: A consume request with fewer than N words present does nothing: no issue, no error and no word removed. `dec_avail_o` is 0 while fewer than `dec_len_i` words are buffered.
- R7: `abort_o` rises together with `acc_err_o` and stays 1 until a flush. While it is 1, consume requests produce neither an issue nor an error and remove no words.
- R8: A flush clears every entry and flag in one cycle, clears `abort_o`, and loads the head address from `flush_pc_i`. Flagged words it discards never produce an error.
- R9: A flush takes priority over a fetch response in the same cycle, and that word is dropped.
- R10: With 4 words buffered `fetch_ready_o` is 0, and a fetch response that arrives then is dropped.
- R11: A fetch response and a consume request in the same cycle both take effect, and word order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Program-flow change: discard buffer |
| flush_pc_i | input | 32 | Byte address of the new flow's first word |
| fetch_valid_i | input | 1 | Fetch response valid |
| fetch_err_i | input | 1 | Fetch response ended in a bus error |
| fetch_word_i | input | 16 | Fetched instruction word |
| fetch_ready_o | output | 1 | Buffer has a free entry |
| dec_take_i | input | 1 | Decode requests consumption of the current instruction |
| dec_len_i | input | 2 | Words in the current instruction (1 to 3) |
| dec_avail_o | output | 1 | All words of the current instruction are buffered |
| instr_issue_o | output | 1 | One-cycle pulse: clean instruction issued |
| instr_words_o | output | 48 | Issued instruction words, first word in the low slot |
| instr_pc_o | output | 32 | Address of the issued instruction |
| acc_err_o | output | 1 | One-cycle access-error exception request |
| acc_err_pc_o | output | 32 | Address of the faulted instruction's first word |
| abort_o | output | 1 | Blocks architectural writes of the aborted instruction |

## Verification
The bench builds the block with its defaults: a buffer depth of 4, instructions of up to 3 words and 32-bit addresses. With these values the bench can fill the buffer and reach the full condition with only four fetches. Every instruction length can be tried with its fault in the opword, in an extension word or just past the end of the instruction. The bench also drives a push and a pop in the same cycle, and a flush in the same cycle as a fetch.

// File: rtl/ift_pkg.sv
package ift_pkg;
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_ISSUE = 2'd1,
        ACT_FAULT = 2'd2,
        ACT_STALL = 2'd3
    } ift_act_e;
endpackage

// File: rtl/ift_word_buf.sv
module ift_word_buf #(
    parameter int WORD_W  = 16,
    parameter int DEPTH   = 4,
    parameter int MAX_LEN = 3,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic                      push_i,
    input  logic [WORD_W-1:0]         push_word_i,
    input  logic                      push_err_i,
    input  logic [LEN_W-1:0]          pop_n_i,
    output logic [MAX_LEN*WORD_W-1:0] head_words_o,
    output logic [MAX_LEN-1:0]        head_flt_o,
    output logic [CNT_W-1:0]          count_o,
    output logic                      ready_o
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] word;
        logic [DEPTH-1:0]             flt;
        logic [CNT_W-1:0]             cnt;
    } buf_state_t;

    buf_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_after;

    always_comb begin
        st_d      = st_q;
        cnt_after = st_q.cnt - CNT_W'(pop_n_i);
        if (flush_i) begin
            st_d.word = '0;
            st_d.flt  = '0;
            st_d.cnt  = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.word[i] = '0;
                st_d.flt[i]  = 1'b0;
                for (int k = 0; k <= MAX_LEN; k++) begin
                    if (pop_n_i == LEN_W'(k) && (i + k) < DEPTH) begin
                        st_d.word[i] = st_q.word[i + k];
                        st_d.flt[i]  = st_q.flt[i + k];
                    end
                end
            end
            st_d.cnt = cnt_after;
            if (push_i && (st_q.cnt < CNT_W'(DEPTH))) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == cnt_after) begin
                        st_d.word[i] = push_word_i;
                        st_d.flt[i]  = push_err_i;
                    end
                end
                st_d.cnt = cnt_after + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < MAX_LEN; g++) begin : g_head
            assign head_words_o[g*WORD_W +: WORD_W] = st_q.word[g];
            assign head_flt_o[g]                    = st_q.flt[g];
        end
    endgenerate

    assign count_o = st_q.cnt;
    assign ready_o = (st_q.cnt < CNT_W'(DEPTH));

    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));

    // R10
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i && !ready_o && pop_n_i == '0) |=> (count_o == CNT_W'(DEPTH)));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_o == '0 && head_flt_o == '0));
endmodule

// File: rtl/ift_consume_check.sv
module ift_consume_check #(
    parameter int DEPTH   = 4,
    parameter int MAX_LEN = 3,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic [MAX_LEN-1:0] head_flt_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic               avail_o,
    output logic               fault_o
);
    logic [MAX_LEN-1:0] in_instr;

    generate
        for (genvar g = 0; g < MAX_LEN; g++) begin : g_mask
            assign in_instr[g] = (LEN_W'(g) < len_i);
        end
    endgenerate

    always_comb begin
        avail_o = (len_i != '0) && (int'(len_i) <= MAX_LEN) && (int'(count_i) >= int'(len_i));
        fault_o = |(head_flt_i & in_instr);
    end
endmodule

// File: rtl/ifetch_fault_tracker.sv
module ifetch_fault_tracker #(
    parameter int           WORD_W   = 16,
    parameter int           DEPTH    = 4,
    parameter int           MAX_LEN  = 3,
    parameter int           ADDR_W   = 32,
    parameter logic [31:0]  RESET_PC = 32'h0,
    localparam int          CNT_W    = $clog2(DEPTH + 1),
    localparam int          LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic [ADDR_W-1:0]         flush_pc_i,
    input  logic                      fetch_valid_i,
    input  logic                      fetch_err_i,
    input  logic [WORD_W-1:0]         fetch_word_i,
    output logic                      fetch_ready_o,
    input  logic                      dec_take_i,
    input  logic [LEN_W-1:0]          dec_len_i,
    output logic                      dec_avail_o,
    output logic                      instr_issue_o,
    output logic [MAX_LEN*WORD_W-1:0] instr_words_o,
    output logic [ADDR_W-1:0]         instr_pc_o,
    output logic                      acc_err_o,
    output logic [ADDR_W-1:0]         acc_err_pc_o,
    output logic                      abort_o
);
    import ift_pkg::*;

    typedef struct packed {
        logic                      issue;
        logic                      err;
        logic                      abort;
        logic [ADDR_W-1:0]         head_pc;
        logic [ADDR_W-1:0]         out_pc;
        logic [MAX_LEN*WORD_W-1:0] words;
    } trk_state_t;

    trk_state_t st_d, st_q;
    ift_act_e   act;
    logic [LEN_W-1:0]          pop_n;
    logic [MAX_LEN*WORD_W-1:0] head_words;
    logic [MAX_LEN-1:0]        head_flt;
    logic [CNT_W-1:0]          count;
    logic                      avail, faulted;

    ift_word_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .push_i       (fetch_valid_i),
        .push_word_i  (fetch_word_i),
        .push_err_i   (fetch_err_i),
        .pop_n_i      (pop_n),
        .head_words_o (head_words),
        .head_flt_o   (head_flt),
        .count_o      (count),
        .ready_o      (fetch_ready_o)
    );

    ift_consume_check #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_chk (
        .head_flt_i (head_flt),
        .count_i    (count),
        .len_i      (dec_len_i),
        .avail_o    (avail),
        .fault_o    (faulted)
    );

    always_comb begin
        act = ACT_NONE;
        if (!flush_i && dec_take_i && !st_q.abort) begin
            if (!avail)       act = ACT_STALL;
            else if (faulted) act = ACT_FAULT;
            else              act = ACT_ISSUE;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.issue = 1'b0;
        st_d.err   = 1'b0;
        pop_n      = '0;
        if (flush_i) begin
            st_d.abort   = 1'b0;
            st_d.head_pc = flush_pc_i;
        end else if (act == ACT_ISSUE || act == ACT_FAULT) begin
            pop_n        = dec_len_i;
            st_d.out_pc  = st_q.head_pc;
            st_d.head_pc = st_q.head_pc + (ADDR_W'(dec_len_i) << 1);
            if (act == ACT_FAULT) begin
                st_d.err   = 1'b1;
                st_d.abort = 1'b1;
                st_d.words = '0;
            end else begin
                st_d.issue = 1'b1;
                for (int i = 0; i < MAX_LEN; i++) begin
                    if (LEN_W'(i) < dec_len_i) begin
                        st_d.words[i*WORD_W +: WORD_W] = head_words[i*WORD_W +: WORD_W];
                    end else begin
                        st_d.words[i*WORD_W +: WORD_W] = '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.head_pc <= ADDR_W'(RESET_PC);
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_avail_o   = avail;
    assign instr_issue_o = st_q.issue;
    assign instr_words_o = st_q.words;
    assign instr_pc_o    = st_q.out_pc;
    assign acc_err_o     = st_q.err;
    assign acc_err_pc_o  = st_q.out_pc;
    assign abort_o       = st_q.abort;

    // R4
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err_o |=> !acc_err_o);

    // R4
    issue_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_err_o && instr_issue_o));

    // R7
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !flush_i) |=> abort_o);

    // R7
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (!instr_issue_o && !acc_err_o));

    // R2
    fetch_err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_err_i && !dec_take_i && !abort_o) |=> (!acc_err_o && !abort_o));

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_take_i && !dec_avail_o) |=> (!instr_issue_o && !acc_err_o));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!abort_o && !acc_err_o && !instr_issue_o && instr_pc_o == $past(instr_pc_o)));
endmodule

// File: tb/ifetch_fault_tracker_bench.sv
module ifetch_fault_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush_i;
    logic [31:0] flush_pc_i;
    logic        fetch_valid_i, fetch_err_i;
    logic [15:0] fetch_word_i;
    logic        fetch_ready_o;
    logic        dec_take_i;
    logic [1:0]  dec_len_i;
    logic        dec_avail_o;
    logic        instr_issue_o;
    logic [47:0] instr_words_o;
    logic [31:0] instr_pc_o;
    logic        acc_err_o;
    logic [31:0] acc_err_pc_o;
    logic        abort_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifetch_fault_tracker u_ifetch_fault_tracker (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_pc_i(flush_pc_i),
        .fetch_valid_i(fetch_valid_i), .fetch_err_i(fetch_err_i), .fetch_word_i(fetch_word_i),
        .fetch_ready_o(fetch_ready_o), .dec_take_i(dec_take_i), .dec_len_i(dec_len_i),
        .dec_avail_o(dec_avail_o), .instr_issue_o(instr_issue_o), .instr_words_o(instr_words_o),
        .instr_pc_o(instr_pc_o), .acc_err_o(acc_err_o), .acc_err_pc_o(acc_err_pc_o),
        .abort_o(abort_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flush_i = 0; fetch_valid_i = 0; fetch_err_i = 0; fetch_word_i = '0;
        dec_take_i = 0; dec_len_i = 2'd1; flush_pc_i = '0;
    endtask

    // Drive at a negedge, let one posedge pass, return at the next negedge.
    task automatic step(input bit fv, input bit fe, input logic [15:0] fw,
                        input bit tk, input logic [1:0] ln,
                        input bit fl, input logic [31:0] fpc);
        fetch_valid_i = fv; fetch_err_i = fe; fetch_word_i = fw;
        dec_take_i = tk; dec_len_i = ln; flush_i = fl; flush_pc_i = fpc;
        @(negedge clk);
        idle();
    endtask

    task automatic fetch(input logic [15:0] w, input bit e);
        step(1, e, w, 0, 2'd1, 0, '0);
    endtask

    task automatic take(input logic [1:0] n);
        step(0, 0, '0, 1, n, 0, '0);
    endtask

    task automatic flush(input logic [31:0] pc);
        step(0, 0, '0, 0, 2'd1, 1, pc);
    endtask

    task automatic expect_issue(input string req, input logic [47:0] w, input logic [31:0] pc);
        check(instr_issue_o === 1'b1, req, "issue", instr_issue_o, 1);
        check(instr_words_o === w, req, "words", instr_words_o, w);
        check(instr_pc_o === pc, req, "issue pc", instr_pc_o, pc);
        check(acc_err_o === 1'b0, req, "no err on issue", acc_err_o, 0);
    endtask

    task automatic expect_err(input string req, input logic [31:0] pc);
        check(acc_err_o === 1'b1, req, "acc_err", acc_err_o, 1);
        check(acc_err_pc_o === pc, req, "err pc", acc_err_pc_o, pc);
        check(instr_issue_o === 1'b0, req, "no issue on err", instr_issue_o, 0);
        check(abort_o === 1'b1, req, "abort", abort_o, 1);
    endtask

    task automatic expect_quiet(input string req);
        check(instr_issue_o === 1'b0, req, "quiet issue", instr_issue_o, 0);
        check(acc_err_o === 1'b0, req, "quiet err", acc_err_o, 0);
    endtask

    task automatic t_reset();
        check(fetch_ready_o === 1'b1, "R1", "ready", fetch_ready_o, 1);
        check(instr_issue_o === 1'b0, "R1", "issue", instr_issue_o, 0);
        check(acc_err_o === 1'b0, "R1", "err", acc_err_o, 0);
        check(abort_o === 1'b0, "R1", "abort", abort_o, 0);
        dec_len_i = 2'd1; #1;
        check(dec_avail_o === 1'b0, "R1", "empty avail", dec_avail_o, 0);
    endtask

    task automatic t_clean_issue();
        flush(32'h100);
        fetch(16'hA001, 0); fetch(16'hA002, 0); fetch(16'hA003, 0);
        take(2'd2);
        expect_issue("R3", {16'h0, 16'hA002, 16'hA001}, 32'h100);
        step(0, 0, '0, 0, 2'd1, 0, '0);
        check(instr_issue_o === 1'b0, "R3", "issue pulse ends", instr_issue_o, 1'b0);
        take(2'd1);
        expect_issue("R3", {16'h0, 16'h0, 16'hA003}, 32'h104);
    endtask

    task automatic t_fault_deferred();
        flush(32'h200);
        fetch(16'hB001, 1);
        check(acc_err_o === 1'b0, "R2", "no err at fetch", acc_err_o, 0);
        check(abort_o === 1'b0, "R2", "no abort at fetch", abort_o, 0);
        fetch(16'hB002, 0);
        check(acc_err_o === 1'b0, "R2", "still no err", acc_err_o, 0);
        take(2'd2);
        expect_err("R4", 32'h200);
        step(0, 0, '0, 0, 2'd1, 0, '0);
        check(acc_err_o === 1'b0, "R4", "err pulse ends", acc_err_o, 0);
        check(abort_o === 1'b1, "R7", "abort held", abort_o, 1);
        flush(32'h300);
        check(abort_o === 1'b0, "R8", "abort cleared by flush", abort_o, 0);
        fetch(16'hC001, 0); fetch(16'hC002, 0); fetch(16'hC003, 1);
        take(2'd3);
        expect_err("R4", 32'h300);
    endtask

    task automatic t_beyond_len();
        flush(32'h400);
        fetch(16'hD001, 0); fetch(16'hD002, 1);
        take(2'd1);
        expect_issue("R5", {16'h0, 16'h0, 16'hD001}, 32'h400);
        take(2'd1);
        expect_err("R5", 32'h402);
    endtask

    task automatic t_stall();
        flush(32'h500);
        fetch(16'hE001, 1);
        dec_len_i = 2'd2; #1;
        check(dec_avail_o === 1'b0, "R6", "avail low with 1 of 2", dec_avail_o, 0);
        take(2'd2);
        expect_quiet("R6");
        check(abort_o === 1'b0, "R6", "no abort on stall", abort_o, 0);
        fetch(16'hE002, 0);
        dec_len_i = 2'd2; #1;
        check(dec_avail_o === 1'b1, "R6", "avail high with 2 of 2", dec_avail_o, 1);
        take(2'd2);
        expect_err("R6", 32'h500);
    endtask

    task automatic t_abort_hold();
        // abort is still set from t_stall
        fetch(16'hF001, 0);
        take(2'd1);
        expect_quiet("R7");
        check(abort_o === 1'b1, "R7", "abort stays", abort_o, 1);
        take(2'd1);
        expect_quiet("R7");
        flush(32'h600);
        check(abort_o === 1'b0, "R7", "abort released by flush", abort_o, 0);
        take(2'd1);
        expect_quiet("R8");
    endtask

    task automatic t_flush_discard();
        flush(32'h700);
        fetch(16'h9001, 1); fetch(16'h9002, 1);
        flush(32'h800);
        expect_quiet("R8");
        check(abort_o === 1'b0, "R8", "no abort after discard", abort_o, 0);
        fetch(16'h8001, 0);
        take(2'd1);
        expect_issue("R8", {16'h0, 16'h0, 16'h8001}, 32'h800);
    endtask

    task automatic t_flush_priority();
        flush(32'h900);
        step(1, 1, 16'h7777, 0, 2'd1, 1, 32'h900);
        dec_len_i = 2'd1; #1;
        check(dec_avail_o === 1'b0, "R9", "word dropped on flush", dec_avail_o, 0);
        take(2'd1);
        expect_quiet("R9");
        fetch(16'h7001, 0);
        take(2'd1);
        expect_issue("R9", {16'h0, 16'h0, 16'h7001}, 32'h900);
    endtask

    task automatic t_full();
        flush(32'hA00);
        fetch(16'h6000, 0); fetch(16'h6001, 0); fetch(16'h6002, 0);
        check(fetch_ready_o === 1'b1, "R10", "ready at 3", fetch_ready_o, 1);
        fetch(16'h6003, 0);
        check(fetch_ready_o === 1'b0, "R10", "not ready at 4", fetch_ready_o, 0);
        fetch(16'h6004, 1);
        take(2'd3);
        expect_issue("R10", {16'h6002, 16'h6001, 16'h6000}, 32'hA00);
        check(fetch_ready_o === 1'b1, "R10", "ready after pop", fetch_ready_o, 1);
        take(2'd1);
        expect_issue("R10", {16'h0, 16'h0, 16'h6003}, 32'hA06);
        take(2'd1);
        expect_quiet("R10");
        check(abort_o === 1'b0, "R10", "dropped fault word absent", abort_o, 0);
    endtask

    task automatic t_push_pop();
        flush(32'hB00);
        fetch(16'h5000, 0); fetch(16'h5001, 0);
        step(1, 0, 16'h5002, 1, 2'd1, 0, '0);
        expect_issue("R11", {16'h0, 16'h0, 16'h5000}, 32'hB00);
        take(2'd2);
        expect_issue("R11", {16'h0, 16'h5002, 16'h5001}, 32'hB02);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_clean_issue();
        t_fault_deferred();
        t_beyond_len();
        t_stall();
        t_abort_hold();
        t_flush_discard();
        t_flush_priority();
        t_full();
        t_push_pop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule